// File: doc/BRIEF.md
# Receive-Side Software Flow-Control Watcher

This block sits beside a UART receiver and looks at every character the receiver completes. It compares each character with four programmed codes: two "stop" codes and two "go" codes. A stop match asks the transmitter to pause. A go match lets the transmitter continue. The codes can be matched as single characters or as back-to-back pairs. The block also raises a flow-control interrupt, and it decides which received characters are handed on to the receive FIFO and which are taken out of the stream.

The transmitter gets a level `tx_halt`. This level rises only when the transmitter reports that it is at a character boundary, so the character being shifted out is never cut short. Three options change the basic behaviour:
- An any-character-resume option lets the first character received after a stop restart transmission.
- A special-character option raises the interrupt when the second stop code is received alone. It does not pause the transmitter.
- An interrupt enable gates whether matches set the interrupt.

Characters leave the block on two registered push lanes, `push_a` and `push_b`. Both lanes are valid one cycle after the character strobe. When both are valid in the same cycle, lane A's character is older and must be written to the FIFO first.

Top module: `rx_flow_watch`

## Requirements
- R1: While `rst` is high, and on any cycle where `cfg_enable` is low, the next state has `tx_halt`=0, `flow_irq`=0, `irq_n`=1 and no partial match. While disabled, a strobed character is pushed on lane B. A character held as a partial match is flushed on lane A.
- R2: In single mode (`cfg_pair`=0), a character equal to `cfg_stop1` enters the stopped state. That character is not pushed.
- R3: In pair mode (`cfg_pair`=1), a stop match needs `cfg_stop1` followed directly by `cfg_stop2` on the next strobed character. Neither character is pushed.
- R4: When a pair has started and the next strobed character is not the expected second code, the held first character is pushed on lane A. The new character is then evaluated afresh: it either starts a new pair or is pushed on lane B.
- R5: `tx_halt` rises only on a clock edge where the block is stopped and `tx_at_boundary` was high. Once raised, it stays high until a resume.
- R6: While stopped, `cfg_go1` alone (single mode) or `cfg_go1` then `cfg_go2` (pair mode) resumes transmission. The matching characters are not pushed. `tx_halt` and `flow_irq` are cleared on the same edge.
- R7: A stop match sets `flow_irq` only when `cfg_irq_en` is 1. `irq_n` is always the inverse of `flow_irq`.
- R8: With `cfg_any_resume`=1, the first character received while stopped resumes transmission. That character is dropped if it equals `cfg_go1` and pushed otherwise. A following `cfg_go2` is pushed as ordinary data.
- R9: With `cfg_special_en`=1, a character equal to `cfg_stop2` that does not complete a stop match sets `flow_irq` when `cfg_irq_en`=1. It does not stop transmission, and it is pushed on lane B.
- R10: A `status_rd` pulse clears an interrupt raised by the special character. It does not clear an interrupt raised by a stop match.
- R11: Push lanes are registered and are valid exactly one cycle after the `rx_valid` strobe. When both lanes are valid, lane A holds the older character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | One-cycle strobe: a received character is complete |
| rx_char | input | W | Received character |
| cfg_enable | input | 1 | Software flow control on |
| cfg_pair | input | 1 | 1: codes match as two-character pairs |
| cfg_any_resume | input | 1 | Any character received while stopped resumes |
| cfg_special_en | input | 1 | Special-character interrupt on second stop code |
| cfg_irq_en | input | 1 | Interrupt enable for flow-control events |
| cfg_stop1 | input | W | First stop code |
| cfg_stop2 | input | W | Second stop code, also the special character |
| cfg_go1 | input | W | First go code |
| cfg_go2 | input | W | Second go code |
| status_rd | input | 1 | Interrupt status read strobe |
| tx_at_boundary | input | 1 | Transmitter is idle or finishing a character |
| tx_halt | output | 1 | Pause request to the transmitter |
| flow_irq | output | 1 | Flow-control interrupt status |
| irq_n | output | 1 | Interrupt line, active low |
| push_a_vld | output | 1 | Lane A push (older character) |
| push_a_data | output | W | Lane A character |
| push_b_vld | output | 1 | Lane B push (newer character) |
| push_b_data | output | W | Lane B character |

## Verification
A wrong internal state shows up on the ports within one cycle of the next character strobe:
- A lost or stale partial match shows as a missing, extra or reordered push on the lanes.
- A stuck stop flag shows as a `tx_halt` level that does not follow the boundary input, or does not fall on a go code.

The interrupt state has two sources. A mix-up between them is exposed by issuing a status read while each source is active and comparing `flow_irq`. A behavioural model that compares every output on every clock catches these faults on the first cycle they differ.

// File: rtl/flow_pkg.sv
package flow_pkg;
    localparam int unsigned CHAR_W  = 8;
    localparam int unsigned N_PAT   = 4;
    localparam int unsigned P_STOP1 = 0;
    localparam int unsigned P_STOP2 = 1;
    localparam int unsigned P_GO1   = 2;
    localparam int unsigned P_GO2   = 3;
endpackage

// File: rtl/flow_cmp.sv
module flow_cmp #(
    parameter int unsigned W = flow_pkg::CHAR_W,
    parameter int unsigned N = flow_pkg::N_PAT
) (
    input  logic [W-1:0]        ch,
    input  logic [N-1:0][W-1:0] pat,
    output logic [N-1:0]        hit
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit[i] = (ch == pat[i]);
    end
endmodule

// File: rtl/rx_flow_watch.sv
module rx_flow_watch #(
    parameter int unsigned W = flow_pkg::CHAR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rx_valid,
    input  logic [W-1:0] rx_char,
    input  logic         cfg_enable,
    input  logic         cfg_pair,
    input  logic         cfg_any_resume,
    input  logic         cfg_special_en,
    input  logic         cfg_irq_en,
    input  logic [W-1:0] cfg_stop1,
    input  logic [W-1:0] cfg_stop2,
    input  logic [W-1:0] cfg_go1,
    input  logic [W-1:0] cfg_go2,
    input  logic         status_rd,
    input  logic         tx_at_boundary,
    output logic         tx_halt,
    output logic         flow_irq,
    output logic         irq_n,
    output logic         push_a_vld,
    output logic [W-1:0] push_a_data,
    output logic         push_b_vld,
    output logic [W-1:0] push_b_data
);
    import flow_pkg::*;

    typedef struct packed {
        logic         stopped;
        logic         part;
        logic [W-1:0] hold;
        logic         halt;
        logic         irq_stop;
        logic         irq_spec;
        logic         pa_v;
        logic [W-1:0] pa_d;
        logic         pb_v;
        logic [W-1:0] pb_d;
    } st_t;

    st_t st_q, st_d;

    logic [N_PAT-1:0][W-1:0] pat;
    logic [N_PAT-1:0]        hit;

    assign pat[P_STOP1] = cfg_stop1;
    assign pat[P_STOP2] = cfg_stop2;
    assign pat[P_GO1]   = cfg_go1;
    assign pat[P_GO2]   = cfg_go2;

    flow_cmp #(.W(W), .N(N_PAT)) u_cmp (
        .ch  (rx_char),
        .pat (pat),
        .hit (hit)
    );

    logic first_hit, second_hit;
    assign first_hit  = st_q.stopped ? hit[P_GO1] : hit[P_STOP1];
    assign second_hit = st_q.stopped ? hit[P_GO2] : hit[P_STOP2];

    always_comb begin
        logic fresh;
        logic complete;
        st_d      = st_q;
        st_d.pa_v = 1'b0;
        st_d.pb_v = 1'b0;
        fresh     = 1'b0;
        complete  = 1'b0;
        if (!cfg_enable) begin
            st_d.pa_v     = st_q.part;
            st_d.pa_d     = st_q.hold;
            st_d.pb_v     = rx_valid;
            st_d.pb_d     = rx_char;
            st_d.part     = 1'b0;
            st_d.stopped  = 1'b0;
            st_d.irq_stop = 1'b0;
            st_d.irq_spec = 1'b0;
            st_d.halt     = 1'b0;
        end else begin
            if (status_rd) st_d.irq_spec = 1'b0;
            if (rx_valid) begin
                fresh = 1'b1;
                if (st_q.part) begin
                    st_d.part = 1'b0;
                    if (second_hit) begin
                        complete = 1'b1;
                        fresh    = 1'b0;
                    end else begin
                        st_d.pa_v = 1'b1;
                        st_d.pa_d = st_q.hold;
                    end
                end else if (st_q.stopped && cfg_any_resume) begin
                    fresh         = 1'b0;
                    st_d.stopped  = 1'b0;
                    st_d.irq_stop = 1'b0;
                    st_d.irq_spec = 1'b0;
                    st_d.pb_v     = !hit[P_GO1];
                    st_d.pb_d     = rx_char;
                end
                if (fresh) begin
                    if (first_hit && cfg_pair) begin
                        st_d.part = 1'b1;
                        st_d.hold = rx_char;
                    end else if (first_hit) begin
                        complete = 1'b1;
                    end else begin
                        st_d.pb_v = 1'b1;
                        st_d.pb_d = rx_char;
                        if (cfg_special_en && hit[P_STOP2] && cfg_irq_en)
                            st_d.irq_spec = 1'b1;
                    end
                end
                if (complete) begin
                    if (!st_q.stopped) begin
                        st_d.stopped = 1'b1;
                        if (cfg_irq_en) st_d.irq_stop = 1'b1;
                    end else begin
                        st_d.stopped  = 1'b0;
                        st_d.irq_stop = 1'b0;
                        st_d.irq_spec = 1'b0;
                    end
                end
            end
            st_d.halt = st_d.stopped && (st_q.halt || tx_at_boundary);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign tx_halt     = st_q.halt;
    assign flow_irq    = st_q.irq_stop | st_q.irq_spec;
    assign irq_n       = ~flow_irq;
    assign push_a_vld  = st_q.pa_v;
    assign push_a_data = st_q.pa_d;
    assign push_b_vld  = st_q.pb_v;
    assign push_b_data = st_q.pb_d;

    AST_HALT_ONLY_STOPPED: assert property (@(posedge clk) disable iff (rst)
        tx_halt |-> st_q.stopped);                                   // R5
    AST_HALT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_halt) |-> $past(tx_at_boundary));                   // R5
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !cfg_enable |=> (!tx_halt && !flow_irq && !st_q.part));       // R1
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        $rose(flow_irq) |-> $past(cfg_irq_en));                      // R7
    AST_LANE_B_FROM_CHAR: assert property (@(posedge clk) disable iff (rst)
        push_b_vld |-> $past(rx_valid));                             // R11
    AST_READ_KEEPS_STOP_IRQ: assert property (@(posedge clk) disable iff (rst)
        (st_q.irq_stop && status_rd && cfg_enable && !rx_valid) |=> st_q.irq_stop); // R10
endmodule

// File: tb/sim_rx_flow_watch.sv
module sim_rx_flow_watch;
    localparam int W = 8;
    localparam logic [7:0] S1 = 8'h13, S2 = 8'h93, G1 = 8'h11, G2 = 8'h91;

    logic clk = 1'b0, rst = 1'b1;
    logic rx_valid = 1'b0;
    logic [W-1:0] rx_char = '0;
    logic cfg_enable = 1'b1, cfg_pair = 1'b0, cfg_any_resume = 1'b0;
    logic cfg_special_en = 1'b0, cfg_irq_en = 1'b1;
    logic status_rd = 1'b0, tx_at_boundary = 1'b1;
    logic tx_halt, flow_irq, irq_n, push_a_vld, push_b_vld;
    logic [W-1:0] push_a_data, push_b_data;

    always #5 clk = ~clk;

    rx_flow_watch #(.W(W)) u0 (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_char(rx_char),
        .cfg_enable(cfg_enable), .cfg_pair(cfg_pair), .cfg_any_resume(cfg_any_resume),
        .cfg_special_en(cfg_special_en), .cfg_irq_en(cfg_irq_en),
        .cfg_stop1(S1), .cfg_stop2(S2), .cfg_go1(G1), .cfg_go2(G2),
        .status_rd(status_rd), .tx_at_boundary(tx_at_boundary),
        .tx_halt(tx_halt), .flow_irq(flow_irq), .irq_n(irq_n),
        .push_a_vld(push_a_vld), .push_a_data(push_a_data),
        .push_b_vld(push_b_vld), .push_b_data(push_b_data)
    );

    int checks = 0, errors = 0;
    string cur_req = "R1";

    // behavioural reference model
    bit m_stop, m_halt, m_irq_x, m_irq_s;
    logic [7:0] m_held[$];
    logic [7:0] m_push[$];

    always @(posedge clk) begin
        logic [7:0] c;
        bit was_stop;
        m_push = {};
        if (rst) begin
            m_stop = 0; m_halt = 0; m_irq_x = 0; m_irq_s = 0; m_held = {};
        end else if (!cfg_enable) begin
            if (m_held.size() > 0) m_push.push_back(m_held.pop_front());
            if (rx_valid) m_push.push_back(rx_char);
            m_stop = 0; m_halt = 0; m_irq_x = 0; m_irq_s = 0;
        end else begin
            if (status_rd) m_irq_s = 0;
            if (rx_valid) begin
                c = rx_char;
                was_stop = m_stop;
                if (m_held.size() > 0 && c == (was_stop ? G2 : S2)) begin
                    void'(m_held.pop_front());
                    if (was_stop) begin m_stop = 0; m_irq_x = 0; m_irq_s = 0; end
                    else begin m_stop = 1; if (cfg_irq_en) m_irq_x = 1; end
                end else begin
                    bit handled;
                    handled = 0;
                    if (m_held.size() > 0) m_push.push_back(m_held.pop_front());
                    else if (was_stop && cfg_any_resume) begin
                        handled = 1;
                        m_stop = 0; m_irq_x = 0; m_irq_s = 0;
                        if (c != G1) m_push.push_back(c);
                    end
                    if (!handled) begin
                        if (c == (was_stop ? G1 : S1)) begin
                            if (cfg_pair) m_held.push_back(c);
                            else if (was_stop) begin m_stop = 0; m_irq_x = 0; m_irq_s = 0; end
                            else begin m_stop = 1; if (cfg_irq_en) m_irq_x = 1; end
                        end else begin
                            m_push.push_back(c);
                            if (cfg_special_en && c == S2 && cfg_irq_en) m_irq_s = 1;
                        end
                    end
                end
            end
            m_halt = m_stop && (m_halt || tx_at_boundary);
        end
    end

    task automatic chk(input bit ok, input string what, input string act, input string exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %s expected %s", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        logic [7:0] got[$];
        if (!rst) begin
            got = {};
            if (push_a_vld) got.push_back(push_a_data);
            if (push_b_vld) got.push_back(push_b_data);
            chk(got == m_push, "pushes", $sformatf("%p", got), $sformatf("%p", m_push));
            chk(tx_halt == m_halt, "tx_halt", $sformatf("%0b", tx_halt), $sformatf("%0b", m_halt));
            chk(flow_irq == (m_irq_x | m_irq_s), "flow_irq",
                $sformatf("%0b", flow_irq), $sformatf("%0b", m_irq_x | m_irq_s));
            chk(irq_n == !(m_irq_x | m_irq_s), "irq_n",
                $sformatf("%0b", irq_n), $sformatf("%0b", !(m_irq_x | m_irq_s)));
        end
    end

    task automatic send(input logic [7:0] c);
        @(negedge clk); #1;
        rx_valid = 1'b1; rx_char = c;
        @(negedge clk); #1;
        rx_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_sim;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_sim();
    end

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R1";
        chk(tx_halt == 0 && flow_irq == 0 && irq_n == 1 && !push_a_vld && !push_b_vld,
            "reset state", $sformatf("%0b%0b%0b", tx_halt, flow_irq, irq_n), "001");
        #1 rst = 1'b0;
        idle(2);
        cur_req = "R2"; send(8'h41); send(S1); idle(2);
        cur_req = "R6"; send(8'h42); send(G1); idle(2);
        cur_req = "R3"; cfg_pair = 1; send(S1); send(S2); idle(2);
        cur_req = "R6"; send(G1); send(G2); idle(2);
        cur_req = "R4"; send(S1); send(8'h43); send(S1); send(S1); send(S2); idle(1);
        send(G1); send(G1); send(G2); idle(2);
        cur_req = "R11"; send(S1); send(S2 ^ 8'h01); send(S1); send(G2); idle(2);
        cur_req = "R5"; cfg_pair = 0; tx_at_boundary = 0; send(S1); idle(4);
        tx_at_boundary = 1; idle(1); #1 tx_at_boundary = 0; idle(3);
        send(G1); idle(1); tx_at_boundary = 1; idle(1);
        cur_req = "R7"; cfg_irq_en = 0; send(S1); idle(2); send(G1); cfg_irq_en = 1; idle(2);
        cur_req = "R8"; cfg_any_resume = 1; send(S1); send(8'h55); idle(1);
        send(S1); send(G1); send(G2); idle(1);
        cfg_pair = 1; send(S1); send(S2); send(G1); send(G2); cfg_pair = 0; cfg_any_resume = 0; idle(2);
        cur_req = "R9"; cfg_special_en = 1; send(S2); idle(2);
        cur_req = "R10"; @(negedge clk); #1 status_rd = 1; @(negedge clk); #1 status_rd = 0; idle(1);
        send(S1); @(negedge clk); #1 status_rd = 1; @(negedge clk); #1 status_rd = 0; idle(1);
        send(S2); @(negedge clk); #1 status_rd = 1; @(negedge clk); #1 status_rd = 0; idle(1);
        send(G1); cfg_special_en = 0; idle(2);
        cur_req = "R1"; cfg_pair = 1; send(S1); send(S2); send(S1);
        @(negedge clk); #1 cfg_enable = 0; idle(1);
        send(S1); send(G1); idle(1); #1 cfg_enable = 1; idle(3);
        finish_sim();
    end
endmodule